// File: doc/BRIEF.md
# Shared-Datapath Cascaded Low-Pass Filter

This block smooths a stream of signed samples through a chain of identical first-order low-pass sections. Each section moves its state toward its input by one power-of-two fraction of the gap between them: `y = y + ((x - y) >>> K)`. The first section takes the block input, and each later section takes the state its predecessor has just written. One subtract, shift and add path serves every section in turn. Each section's state sits in a small register bank, so adding sections costs state storage and frame cycles but no extra arithmetic.

Time is divided into frames of `FRAME_LEN` clocks. In clock `i` of a frame, section `i` is updated. Clocks at or beyond the section count do no work. `FRAME_LEN` is set separately from the section count, which lets the output rate be matched to an audio sample rate derived from the clock. The input is sampled on the first clock of each frame. The result of the last section is placed on the output at the end of the frame, together with a one-clock strobe.

Top module: `pow2_iir_cascade`

## Requirements
- R1: A synchronous active-high reset sets `dout` to 0, clears `dout_vld`, clears every section's state, and returns the frame counter to its first cycle. After reset, frames with a zero input therefore produce a zero output.
- R2: `dout_vld` is high for exactly one clock out of every `FRAME_LEN` clocks. The first pulse appears `FRAME_LEN` clocks after reset is released. `dout` changes only on the clock edge that raises `dout_vld`.
- R3: Within a frame, section s (s = 0..STAGES-1) is updated in ascending order as `y[s] += (x[s] - y[s]) >>> K_SHIFT`. Here `x[0]` is the frame's input and `x[s]` is the value `y[s-1]` took earlier in the same frame. `dout` is the final `y[STAGES-1]` of the frame.
- R4: A step from rest reaches every section in the same frame it is applied. For example, with K_SHIFT=4, STAGES=4 and input 2^20 from zero state, the first output is 16 (2^20 -> 2^16 -> 2^12 -> 2^8 -> 2^4).
- R5: The difference is formed one bit wider than the data, so full-scale steps between -2^(DATA_W-1) and 2^(DATA_W-1)-1 never wrap. Every written state lies between that section's input and its old state.
- R6: `din` is sampled only on the first clock edge of a frame. Its value during the other clocks of the frame has no effect on any output.
- R7: The shift is arithmetic and rounds toward minus infinity. From zero state, an input of -1 drives every section, and so the first output, to -1. An input of +1 leaves the output at 0 for as long as it is held.
- R8: Sections are written only in frame cycles 0..STAGES-1. Idle cycles leave all states unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Signed input sample, taken on the first clock of each frame |
| dout | output | DATA_W | Signed filtered output, held between strobes |
| dout_vld | output | 1 | One-clock strobe marking a new `dout` |

## Verification
The bench targets full-scale steps in both directions. A design that formed the difference at data width would wrap there, and the output would jump to the wrong sign. It holds inputs of +1 and -1 against a zero state: a logical shift, or one that rounds toward zero, would move the output in the wrong case. It checks the very first frame after a step. A design that fed each section last frame's value from its predecessor would output 0 there instead of the cascaded value. It also scrambles `din` between frame starts, which would corrupt results in a design that sampled the input late. The pulse spacing is checked as well, which catches a counter that wraps early or late.

// File: rtl/iir_cascade_pkg.sv
package iir_cascade_pkg;

    // Index width that stays at least one bit for single-entry ranges.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iir_frame_seq.sv
module iir_frame_seq
    import iir_cascade_pkg::*;
#(
    parameter int FRAME_LEN = 6,
    parameter int STAGES    = 4,
    localparam int CNT_W    = idx_width(FRAME_LEN),
    localparam int AW       = idx_width(STAGES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CNT_W-1:0] cnt,
    output logic          stage_we,
    output logic [AW-1:0] stage_idx,
    output logic          frame_end
);
    localparam logic [CNT_W-1:0] LAST_CYC   = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_STAGE = CNT_W'(STAGES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        frame_end = (cnt_q == LAST_CYC);
        stage_we  = (cnt_q <= LAST_STAGE);
        stage_idx = cnt_q[AW-1:0];
        cnt_d     = frame_end ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/iir_state_bank.sv
module iir_state_bank #(
    parameter int DATA_W = 24,
    parameter int STAGES = 4,
    parameter int AW     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            idx,
    input  logic signed [DATA_W-1:0] wdata,
    output logic signed [DATA_W-1:0] rd_self,
    output logic signed [DATA_W-1:0] rd_prev,
    output logic signed [DATA_W-1:0] rd_last
);
    logic signed [DATA_W-1:0] state_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic signed [DATA_W-1:0] state_d;
        always_comb begin
            state_d = state_q[g];
            if (we && idx == AW'(g)) state_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (rst) state_q[g] <= '0;
            else     state_q[g] <= state_d;
        end
    end

    always_comb begin
        rd_self = state_q[idx];
        rd_prev = (idx == '0) ? '0 : state_q[idx - AW'(1)];
        rd_last = state_q[STAGES-1];
    end
endmodule

// File: rtl/iir_shift_update.sv
module iir_shift_update #(
    parameter int DATA_W  = 24,
    parameter int K_SHIFT = 4
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] y,
    output logic signed [DATA_W-1:0] y_new
);
    logic signed [DATA_W:0] diff_wide;
    logic signed [DATA_W:0] step_wide;
    logic signed [DATA_W:0] sum_wide;

    always_comb begin
        diff_wide = {x[DATA_W-1], x} - {y[DATA_W-1], y};
        step_wide = diff_wide >>> K_SHIFT;
        sum_wide  = {y[DATA_W-1], y} + step_wide;
        y_new     = sum_wide[DATA_W-1:0];
    end
endmodule

// File: rtl/pow2_iir_cascade.sv
module pow2_iir_cascade
    import iir_cascade_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int K_SHIFT   = 4,
    parameter int STAGES    = 4,
    parameter int FRAME_LEN = 6,
    localparam int CNT_W    = idx_width(FRAME_LEN),
    localparam int AW       = idx_width(STAGES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout,
    output logic                     dout_vld
);
    typedef struct packed {
        logic signed [DATA_W-1:0] dout;
        logic                     vld;
    } out_t;

    out_t out_d, out_q;

    logic [CNT_W-1:0]         cnt_q;
    logic                     stage_we;
    logic [AW-1:0]            stage_idx;
    logic                     frame_end;
    logic signed [DATA_W-1:0] y_cur, y_prev, y_last, x_sel, y_new, last_now;

    iir_frame_seq #(.FRAME_LEN(FRAME_LEN), .STAGES(STAGES)) u_seq (
        .clk(clk), .rst(rst), .cnt(cnt_q), .stage_we(stage_we),
        .stage_idx(stage_idx), .frame_end(frame_end)
    );

    iir_state_bank #(.DATA_W(DATA_W), .STAGES(STAGES), .AW(AW)) u_bank (
        .clk(clk), .rst(rst), .we(stage_we), .idx(stage_idx), .wdata(y_new),
        .rd_self(y_cur), .rd_prev(y_prev), .rd_last(y_last)
    );

    iir_shift_update #(.DATA_W(DATA_W), .K_SHIFT(K_SHIFT)) u_upd (
        .x(x_sel), .y(y_cur), .y_new(y_new)
    );

    always_comb begin
        x_sel    = (stage_idx == '0) ? din : y_prev;
        // Bypass when the last stage is written in the frame's final cycle.
        last_now = (stage_we && stage_idx == AW'(STAGES - 1)) ? y_new : y_last;
        out_d.vld  = frame_end;
        out_d.dout = frame_end ? last_now : out_q.dout;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign dout     = out_q.dout;
    assign dout_vld = out_q.vld;
endmodule

// File: rtl/pow2_iir_cascade_chk.sv
module pow2_iir_cascade_chk #(
    parameter int DATA_W    = 24,
    parameter int STAGES    = 4,
    parameter int FRAME_LEN = 6,
    parameter int CNT_W     = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     dout_vld,
    input logic signed [DATA_W-1:0] dout,
    input logic [CNT_W-1:0]         cnt,
    input logic                     we,
    input logic signed [DATA_W-1:0] x_in,
    input logic signed [DATA_W-1:0] y_old,
    input logic signed [DATA_W-1:0] y_wr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (dout == '0 && !dout_vld));

    // R2
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> (cnt == '0));

    if (FRAME_LEN > 1) begin : g_gap
        // R2
        strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
            dout_vld |=> !dout_vld);
    end

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> dout_vld);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> ((x_in >= y_old) ? (y_wr >= y_old && y_wr <= x_in)
                                : (y_wr <= y_old && y_wr >= x_in)));

    // R8
    idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (cnt < CNT_W'(STAGES)));
endmodule

bind pow2_iir_cascade pow2_iir_cascade_chk #(
    .DATA_W(DATA_W), .STAGES(STAGES), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .dout_vld(dout_vld), .dout(dout), .cnt(cnt_q),
    .we(stage_we), .x_in(x_sel), .y_old(y_cur), .y_wr(y_new)
);

// File: tb/pow2_iir_cascade_test.sv
`timescale 1ns/1ps
module pow2_iir_cascade_test;
    localparam int DATA_W    = 24;
    localparam int K_SHIFT   = 4;
    localparam int STAGES    = 4;
    localparam int FRAME_LEN = 6;
    localparam longint MAXV  = (64'sd1 <<< (DATA_W - 1)) - 1;
    localparam longint MINV  = -(64'sd1 <<< (DATA_W - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DATA_W-1:0] din = '0;
    logic signed [DATA_W-1:0] dout;
    logic dout_vld;

    int checks = 0;
    int errors = 0;
    longint st [STAGES];

    always #2 clk = ~clk;

    pow2_iir_cascade #(.DATA_W(DATA_W), .K_SHIFT(K_SHIFT), .STAGES(STAGES),
        .FRAME_LEN(FRAME_LEN)) uut (
        .clk(clk), .rst(rst), .din(din), .dout(dout), .dout_vld(dout_vld));

    function automatic longint model_frame(input longint x0);
        longint x;
        for (int s = 0; s < STAGES; s++) begin
            x = (s == 0) ? x0 : st[s-1];
            st[s] = st[s] + ((x - st[s]) >>> K_SHIFT);
        end
        return st[STAGES-1];
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 dout in reset", longint'(dout), 0);
        check("R1 strobe in reset", longint'(dout_vld), 0);
        for (int s = 0; s < STAGES; s++) st[s] = 0;
        rst = 1'b0;
    endtask

    // Called at a negedge in frame cycle 0 (right after reset or a strobe).
    task automatic run_frame(input longint val, input bit glitch, input string req);
        longint exp;
        int gap;
        din = DATA_W'(val);
        exp = model_frame(val);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (glitch && gap == 1) din = ~din; // R6: late change must be ignored
        end while (!dout_vld && gap < 4 * FRAME_LEN);
        check("R2 strobe spacing", gap, FRAME_LEN);
        check(req, longint'(dout), exp);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint v;
        void'($urandom(32'd2718));
        do_reset();
        // R1: zero input after reset stays zero
        run_frame(0, 0, "R1 zero after reset");
        // R4: step propagates through every stage in one frame
        run_frame(64'sd1 <<< 20, 0, "R4 same-frame cascade");
        check("R4 first value", longint'(dout), 16);
        for (int i = 0; i < 20; i++) run_frame(64'sd1 <<< 20, 0, "R3 step settle");

        // R7: floor rounding of the arithmetic shift
        do_reset();
        run_frame(-1, 0, "R7 minus one");
        check("R7 minus one reaches output", longint'(dout), -1);
        do_reset();
        for (int i = 0; i < 5; i++) run_frame(1, 0, "R7 plus one stuck");
        check("R7 plus one output", longint'(dout), 0);

        // R5: full-scale steps both ways
        do_reset();
        for (int i = 0; i < 40; i++) run_frame(MAXV, 0, "R5 rise full scale");
        for (int i = 0; i < 40; i++) run_frame(MINV, 0, "R5 fall full scale");
        for (int i = 0; i < 10; i++) run_frame(MAXV, 0, "R5 swing back");

        // R6: input scrambled after the sampling edge
        for (int i = 0; i < 10; i++) run_frame(-12345, 1, "R6 late din ignored");

        // R3/R8: random inputs, some frames scrambled
        for (int i = 0; i < 150; i++) begin
            v = longint'($signed(DATA_W'($urandom)));
            run_frame(v, ($urandom % 3) == 0, "R3 random frame");
        end

        // R1: mid-run reset clears state
        do_reset();
        for (int i = 0; i < 3; i++) run_frame(0, 0, "R1 state cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule